// File: doc/BRIEF.md
# Port soft-reset handshake controller

This block puts one accelerator port into a soft reset and takes it back out under software control, with a two-phase acknowledge. Software writes a request bit in a small control register. The block then stops the port from issuing new transactions. It waits until every transaction the port already issued has completed, and holds the port in reset for at least a programmable number of cycles. Only after that does it raise a read-only acknowledge bit in the same register.

When software clears the request, the acknowledge does not drop at once. The block runs a release sequence of configurable length, and the acknowledge falls only when the port is fully out of reset. Software therefore treats a 1 on the acknowledge as "reset is in force" and the following 0 as "the port is usable again". It never assumes a fixed delay.

The block tracks outstanding traffic with an internal counter. An issue strobe increments the counter and a completion strobe decrements it. The counter keeps running while issue is blocked, so the drain can finish.

Top module: `port_softrst_ctrl`

## Requirements
- R1: After a hard reset the control read-back is all zeros, `port_rst` is 0 and `port_en` is 1.
- R2: Bit 0 of the control register is the reset request. It reads back what was last written. Writing 1 while idle raises `port_rst` and lowers `port_en` one cycle after the write edge.
- R3: The acknowledge (bit 1 of the read-back) stays 0 while any issued transaction is still outstanding. Completions that arrive while issue is blocked are still counted.
- R4: Let W be the request write edge and D the edge of the last pending completion (use D = W if none is pending). The acknowledge becomes 1 at edge max(W+2, D+1) + MIN_WIDTH. In every case `port_rst` has been high for at least MIN_WIDTH cycles.
- R5: Clearing the request at edge C while acknowledged leaves the acknowledge at 1. It falls at edge C+1+EXIT_CYCLES.
- R6: `port_rst` is high from the first drain cycle until the release sequence ends. It falls in the same cycle as the acknowledge.
- R7: `port_en` is low exactly while `port_rst` is high. The port raises no issue strobe then.
- R8: The acknowledge bit is read-only. Writing a 1 to bit 1 changes neither the read-back nor `port_rst`.
- R9: If the request is cleared before the acknowledge rises, the drain and minimum width still complete. The acknowledge then rises at the R4 edge A and falls at edge A+EXIT_CYCLES, with no wait in the acknowledged state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, synchronous |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W | Write data; bit 0 request, bit 1 ignored |
| ctl_rdata | output | CTL_W | Read-back; bit 0 request, bit 1 acknowledge, rest 0 |
| txn_issue | input | 1 | Port issued one transaction this cycle |
| txn_done | input | 1 | One outstanding transaction completed this cycle |
| port_en | output | 1 | Port may issue new transactions |
| port_rst | output | 1 | Soft reset to the port |

## Verification
The assertions assume the port honours `port_en`: it never strobes `txn_issue` while that output is low. They also assume the port never reports more completions than it issued, so the outstanding count neither wraps below zero nor past its maximum. The stimulus issues transactions only while the block is idle. It returns exactly one completion for each issue, spaced apart, during the drain. Every request is held until either the acknowledge is seen or a deliberate early clear is being tested.

// File: rtl/psr_pkg.sv
package psr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DRAIN,
      ST_HOLD,
      ST_ASSERTED,
      ST_RELEASE
   } psr_state_e;

   localparam int REQ_BIT = 0;
   localparam int ACK_BIT = 1;
endpackage

// File: rtl/psr_txn_counter.sv
module psr_txn_counter #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             empty
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)              count <= '0;
      else if (inc && !dec)    count <= count + 1'b1;
      else if (dec && !inc)    count <= count - 1'b1;
   end

   assign empty = (count == '0);

   // completions never exceed issues (input assumption)
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> !(dec && !inc));
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_MAX) |-> !(inc && !dec));
endmodule

// File: rtl/psr_cycle_timer.sv
module psr_cycle_timer #(
   parameter int TMR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   output logic             zero
);
   logic [TMR_W-1:0] val;

   always_ff @(posedge clk) begin
      if (!rst_n)          val <= '0;
      else if (load)       val <= load_val;
      else if (val != '0)  val <= val - 1'b1;
   end

   assign zero = (val == '0);
endmodule

// File: rtl/psr_seq_fsm.sv
module psr_seq_fsm
   import psr_pkg::*;
#(
   parameter int MIN_WIDTH   = 8,
   parameter int EXIT_CYCLES = 5,
   parameter int TMR_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             drained,
   input  logic             tmr_zero,
   output logic             tmr_load,
   output logic [TMR_W-1:0] tmr_val,
   output logic             ack,
   output logic             port_rst,
   output logic             port_en
);
   localparam logic [TMR_W-1:0] HOLD_LOAD = TMR_W'(MIN_WIDTH - 1);
   localparam logic [TMR_W-1:0] EXIT_LOAD = TMR_W'(EXIT_CYCLES - 1);

   psr_state_e state, state_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   always_comb begin
      state_nx = state;
      tmr_load = 1'b0;
      tmr_val  = HOLD_LOAD;
      case (state)
         ST_IDLE:
            if (req) state_nx = ST_DRAIN;
         ST_DRAIN:
            if (drained) begin
               state_nx = ST_HOLD;
               tmr_load = 1'b1;
               tmr_val  = HOLD_LOAD;
            end
         ST_HOLD:
            if (tmr_zero) begin
               if (req) state_nx = ST_ASSERTED;
               else begin
                  state_nx = ST_RELEASE;
                  tmr_load = 1'b1;
                  tmr_val  = EXIT_LOAD;
               end
            end
         ST_ASSERTED:
            if (!req) begin
               state_nx = ST_RELEASE;
               tmr_load = 1'b1;
               tmr_val  = EXIT_LOAD;
            end
         ST_RELEASE:
            if (tmr_zero) state_nx = ST_IDLE;
         default:
            state_nx = ST_IDLE;
      endcase
   end

   assign ack      = (state == ST_ASSERTED) || (state == ST_RELEASE);
   assign port_rst = (state != ST_IDLE);
   assign port_en  = (state == ST_IDLE);

   // acknowledge is only ever raised by the sequencer leaving the hold phase
   assert_ack_from_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(state) == ST_HOLD);
   assert_rst_ack_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack) |-> $fell(port_rst));
endmodule

// File: rtl/port_softrst_ctrl.sv
module port_softrst_ctrl
   import psr_pkg::*;
#(
   parameter int CTL_W       = 2,
   parameter int CNT_W       = 6,
   parameter int MIN_WIDTH   = 8,
   parameter int EXIT_CYCLES = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   input  logic             txn_issue,
   input  logic             txn_done,
   output logic             port_en,
   output logic             port_rst
);
   localparam int MAXV  = (MIN_WIDTH > EXIT_CYCLES) ? MIN_WIDTH : EXIT_CYCLES;
   localparam int TMR_W = $clog2(MAXV + 1);
   localparam int RUN_W = $clog2(MIN_WIDTH + 1);

   if (CTL_W < 2)       begin : g_bad_ctl  $error("CTL_W must be at least 2"); end
   if (CNT_W < 1)       begin : g_bad_cnt  $error("CNT_W must be at least 1"); end
   if (MIN_WIDTH < 1)   begin : g_bad_min  $error("MIN_WIDTH must be at least 1"); end
   if (EXIT_CYCLES < 1) begin : g_bad_exit $error("EXIT_CYCLES must be at least 1"); end

   logic             req_q;
   logic             ack;
   logic             drained;
   logic [CNT_W-1:0] outstanding;
   logic             tmr_load, tmr_zero;
   logic [TMR_W-1:0] tmr_val;
   logic             unused_wbits;

   always_ff @(posedge clk) begin
      if (!rst_n)      req_q <= 1'b0;
      else if (ctl_wr) req_q <= ctl_wdata[REQ_BIT];
   end
   assign unused_wbits = &{1'b0, ctl_wdata};

   psr_txn_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .inc(txn_issue), .dec(txn_done),
      .count(outstanding), .empty(drained));

   psr_cycle_timer #(.TMR_W(TMR_W)) i_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .zero(tmr_zero));

   psr_seq_fsm #(.MIN_WIDTH(MIN_WIDTH), .EXIT_CYCLES(EXIT_CYCLES),
                 .TMR_W(TMR_W)) i_fsm (
      .clk(clk), .rst_n(rst_n), .req(req_q), .drained(drained),
      .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
      .ack(ack), .port_rst(port_rst), .port_en(port_en));

   for (genvar b = 0; b < CTL_W; b++) begin : g_rd
      if (b == REQ_BIT)      begin : g_req assign ctl_rdata[b] = req_q; end
      else if (b == ACK_BIT) begin : g_ack assign ctl_rdata[b] = ack;   end
      else                   begin : g_pad assign ctl_rdata[b] = 1'b0;  end
   end

   // run length of the current reset pulse, saturating at MIN_WIDTH
   logic [RUN_W-1:0] rst_run;
   always_ff @(posedge clk) begin
      if (!rst_n || !port_rst)                 rst_run <= '0;
      else if (rst_run != RUN_W'(MIN_WIDTH))   rst_run <= rst_run + 1'b1;
   end

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |=> port_rst);
   assert_ack_needs_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> (outstanding == '0));
   assert_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> (rst_run >= RUN_W'(MIN_WIDTH)));
   assert_ack_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack) |-> !$past(req_q));
   assert_no_issue_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |-> !txn_issue);
endmodule

// File: tb/test_port_softrst_ctrl.sv
`timescale 1ns/1ps
module test_port_softrst_ctrl;
   localparam int MIN_W  = 8;
   localparam int EXIT_C = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [1:0] ctl_wdata = '0;
   logic [1:0] ctl_rdata;
   logic       txn_issue = 1'b0;
   logic       txn_done = 1'b0;
   logic       port_en, port_rst;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int exp_q[$];
   logic ack_prev = 1'b0;

   always #2 clk = ~clk;

   port_softrst_ctrl #(.CTL_W(2), .CNT_W(6), .MIN_WIDTH(MIN_W),
                       .EXIT_CYCLES(EXIT_C)) i_port_softrst_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .txn_issue(txn_issue), .txn_done(txn_done),
      .port_en(port_en), .port_rst(port_rst));

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: every acknowledge edge is compared with the next expected edge
   always @(negedge clk) begin
      if (rst_n && (ctl_rdata[1] !== ack_prev)) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R4 unexpected ack edge: actual=%0d expected=none", cyc);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (cyc != e) begin
               n_fail++;
               $display("FAIL %s ack edge: actual=%0d expected=%0d",
                        ctl_rdata[1] ? "R4" : "R5", cyc, e);
            end
         end
      end
      ack_prev = ctl_rdata[1];
   end

   task automatic reg_write(input logic [1:0] d, output int edge_n);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = d;
      @(posedge clk);
      #1;
      edge_n = cyc;
      ctl_wr = 1'b0;
   endtask

   task automatic issue_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         txn_issue = 1'b1;
         @(posedge clk);
         #1 txn_issue = 1'b0;
      end
   endtask

   task automatic done_one(output int edge_n);
      @(negedge clk);
      txn_done = 1'b1;
      @(posedge clk);
      #1;
      edge_n = cyc;
      txn_done = 1'b0;
   endtask

   task automatic wait_ack(input logic v);
      @(negedge clk);
      while (ctl_rdata[1] !== v) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int w, c, d;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 rdata", ctl_rdata, 0);
      chk("R1 port_rst", port_rst, 0);
      chk("R1 port_en", port_en, 1);
      rst_n = 1'b1;

      // R8: writing the acknowledge bit alone has no effect
      reg_write(2'b10, w);
      @(negedge clk);
      chk("R8 rdata after ack write", ctl_rdata, 0);
      repeat (3) @(negedge clk);
      chk("R8 port_rst after ack write", port_rst, 0);

      // nothing outstanding: full two-phase handshake
      reg_write(2'b01, w);
      exp_q.push_back(w + 2 + MIN_W);
      @(negedge clk);
      chk("R2 request readback", ctl_rdata[0], 1);
      @(negedge clk);
      chk("R2 port_rst raised", port_rst, 1);
      chk("R7 port_en low", port_en, 0);
      wait_ack(1'b1);
      repeat (4) @(negedge clk);
      reg_write(2'b10, c);   // clear request, try to write ack
      exp_q.push_back(c + 1 + EXIT_C);
      @(negedge clk);
      chk("R5 ack held after clear", ctl_rdata[1], 1);
      chk("R8 request cleared, ack bit ignored", ctl_rdata[0], 0);
      chk("R6 port_rst during release", port_rst, 1);
      wait_ack(1'b0);
      chk("R6 port_rst falls with ack", port_rst, 0);
      chk("R7 port_en back", port_en, 1);
      repeat (3) @(negedge clk);

      // three outstanding, completions spread across the drain
      issue_n(3);
      reg_write(2'b01, w);
      repeat (3) @(negedge clk);
      chk("R7 port_en low in drain", port_en, 0);
      done_one(d);
      repeat (2) @(negedge clk);
      done_one(d);
      repeat (2) @(negedge clk);
      chk("R3 no ack with one outstanding", ctl_rdata[1], 0);
      done_one(d);
      exp_q.push_back(d + 1 + MIN_W);
      wait_ack(1'b1);
      chk("R3 ack after drain", ctl_rdata[1], 1);
      repeat (2) @(negedge clk);
      reg_write(2'b00, c);
      exp_q.push_back(c + 1 + EXIT_C);
      wait_ack(1'b0);
      chk("R6 port_rst low after release", port_rst, 0);
      repeat (3) @(negedge clk);

      // R9: request withdrawn during the drain
      issue_n(2);
      reg_write(2'b01, w);
      repeat (2) @(negedge clk);
      reg_write(2'b00, c);
      @(negedge clk);
      chk("R9 ack low before drain", ctl_rdata[1], 0);
      chk("R9 port_rst held", port_rst, 1);
      done_one(d);
      repeat (3) @(negedge clk);
      done_one(d);
      exp_q.push_back(d + 1 + MIN_W);
      exp_q.push_back(d + 1 + MIN_W + EXIT_C);
      wait_ack(1'b1);
      chk("R9 request still clear", ctl_rdata[0], 0);
      wait_ack(1'b0);
      chk("R9 port_rst low at end", port_rst, 0);
      chk("R9 port_en high at end", port_en, 1);
      repeat (3) @(negedge clk);

      chk("R4 all expected ack edges seen", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule